// File: doc/BRIEF.md
# Ethernet PHY LED Function Controller

This block turns the live status of an Ethernet PHY into drive for four indicator LEDs. Status inputs are link up, link speed, power-down, energy-efficient mode, auto-negotiation, analog self-test, cable diagnostics and test mode. Activity inputs are transmit, receive and collision. Each LED has two configuration bytes. The high byte selects the condition that holds the LED steadily on and the condition that blinks it fast. The low byte selects the condition that blinks it slowly and a mask of the activity events that pulse it.

Shared settings choose the fast and slow blink rates from 2, 4, 8 and 16 Hz. Two further 3-bit selectors pick a condition that takes over all LEDs. One makes every LED blink together at the slow rate. The other steps a single lit LED across the row at the fast rate.

A free-running prescaler divides the system clock into 64 ticks per second. Every blink wave is a bit of one tick counter, so LEDs that blink at the same rate stay in phase. The configuration bytes arrive as plain inputs from registers held elsewhere.

Top module: `phy_led_ctrl`

## Requirements
- R1: While `rst_n` is low, every bit of `led_out` is 0 and the prescaler and scan position are cleared.
- R2: The prescaler produces one tick every `CLK_HZ/64` clock cycles. A rate code of 0, 1, 2 or 3 selects a square wave of 32, 16, 8 or 4 ticks period (2, 4, 8 or 16 Hz), each with a 50% duty cycle.
- R3: The constant-on selector (high byte bits 7:4) lights the LED steadily when its condition holds. The codes are:
  - 1: 10M
  - 2: 100M
  - 3: 10M or 100M
  - 4: 1000M
  - 5: 10M or 1000M
  - 6: 100M or 1000M
  - 7: any speed
  - 8: power-down
  - 9: energy-efficient mode
  - A: auto-negotiation
  - B: self-test
  - C: cable diagnostics

  Every speed code requires `link_up`. `link_speed` is 0 for 10M, 1 for 100M and 2 for 1000M; 3 matches no speed.
- R4: The fast-blink selector (high byte bits 3:0) and the slow-blink selector (low byte bits 7:4) use the same codes as R3. Code 0 and codes D to F never light the LED.
- R5: Pulse mask bits select which events pulse the LED:
  - low byte bit 0: transmit
  - low byte bit 1: receive
  - low byte bit 2: collision
  - low byte bit 3: reserved, never pulses

  A selected event lights the LED for `2*CLK_HZ/64` cycles and then holds it dark for the same count. Events that arrive during either phase are ignored.
- R6: The per-LED priority, from highest to lowest, is:
  1. activity pulse (both its lit and dark phases)
  2. fast blink
  3. slow blink
  4. constant on

  If none of these applies, the LED is off.
- R7: The group-blink selector is a 3-bit code:
  - 0: none
  - 1: link up
  - 2: power-down
  - 3: energy-efficient mode
  - 4: auto-negotiation
  - 5: self-test
  - 6: cable diagnostics
  - 7: test mode

  While its condition holds, all LEDs show the slow wave together and per-LED settings are ignored.
- R8: While the scan condition holds (same codes as R7), exactly one LED is lit. The lit position starts at LED0 and moves to the next higher LED once per fast-rate period, wrapping from the last LED back to LED0. Scan takes precedence over group blink.
- R9: LEDs blinking at the same rate are in phase.
- R10: `led_out` is registered. A change on any input shows on `led_out` after one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link is established |
| link_speed | input | 2 | 0 = 10M, 1 = 100M, 2 = 1000M, 3 = none |
| power_down | input | 1 | PHY is powered down |
| eee_active | input | 1 | Energy-efficient mode is active |
| aneg_busy | input | 1 | Auto-negotiation is running |
| selftest_busy | input | 1 | Analog self-test is running |
| cablediag_busy | input | 1 | Cable diagnostics are running |
| testmode_on | input | 1 | Test mode is active |
| act_tx | input | 1 | Transmit activity event |
| act_rx | input | 1 | Receive activity event |
| act_col | input | 1 | Collision event |
| fast_rate | input | 2 | Fast blink rate code (R2) |
| slow_rate | input | 2 | Slow blink rate code (R2) |
| scan_cond | input | 3 | Scan condition code (R8) |
| gblink_cond | input | 3 | Group-blink condition code (R7) |
| led_hi_cfg | input | NUM_LED*8 | Per-LED high bytes, LED i in bits 8i+7:8i |
| led_lo_cfg | input | NUM_LED*8 | Per-LED low bytes, LED i in bits 8i+7:8i |
| led_out | output | NUM_LED | LED drive, 1 = lit |

## Verification
The bench targets the decoder corners:
- Speed code 3 with the link up, and selector codes D to F with every status input set. A decoder that falls through to a default-on branch or aliases the top codes would light these LEDs.
- The reserved pulse-mask bit. A design that treats it as a selector would light the LED.
- A retrigger during the dark phase of a pulse. A design without the gap phase would show a second pulse.
- The dark phase of a pulse while constant-on is active. A design that gives a pulse priority only while it is lit would let the LED glow through the gap.

The scan is checked for:
- its starting LED, its step order and its step interval;
- taking precedence over group blink.

Blink periods and high times are measured against the rate codes at both ends of the range. Two LEDs at the same rate are compared sample by sample. Both checks catch a swapped rate field or a per-LED divider.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;

  // Tick counter: 64 ticks per second, so a 2 Hz wave spans 32 ticks.
  localparam int TICKS_PER_S = 64;
  localparam int TCNT_W      = 5;

  typedef enum logic [1:0] {
    SPD_10   = 2'd0,
    SPD_100  = 2'd1,
    SPD_1000 = 2'd2,
    SPD_NONE = 2'd3
  } speed_e;

  typedef struct packed {
    logic       link;
    logic [1:0] speed;
    logic       pdown;
    logic       eee;
    logic       aneg;
    logic       abist;
    logic       cdiag;
    logic       test;
  } phy_stat_t;

  // Suggested power-on contents for the external configuration registers.
  localparam logic [31:0] DEF_LED_HI = 32'h4040_2070;
  localparam logic [31:0] DEF_LED_LO = 32'h2000_0003;

  // 4-bit per-LED condition decode (constant-on, fast and slow blink).
  function automatic logic led_cond(input logic [3:0] code, input phy_stat_t s);
    logic l10, l100, l1000;
    l10   = s.link && (s.speed == SPD_10);
    l100  = s.link && (s.speed == SPD_100);
    l1000 = s.link && (s.speed == SPD_1000);
    case (code)
      4'h1:    led_cond = l10;
      4'h2:    led_cond = l100;
      4'h3:    led_cond = l10 || l100;
      4'h4:    led_cond = l1000;
      4'h5:    led_cond = l10 || l1000;
      4'h6:    led_cond = l100 || l1000;
      4'h7:    led_cond = l10 || l100 || l1000;
      4'h8:    led_cond = s.pdown;
      4'h9:    led_cond = s.eee;
      4'hA:    led_cond = s.aneg;
      4'hB:    led_cond = s.abist;
      4'hC:    led_cond = s.cdiag;
      default: led_cond = 1'b0;
    endcase
  endfunction

  // 3-bit group condition decode (scan and group blink).
  function automatic logic grp_cond(input logic [2:0] code, input phy_stat_t s);
    case (code)
      3'd1:    grp_cond = s.link;
      3'd2:    grp_cond = s.pdown;
      3'd3:    grp_cond = s.eee;
      3'd4:    grp_cond = s.aneg;
      3'd5:    grp_cond = s.abist;
      3'd6:    grp_cond = s.cdiag;
      3'd7:    grp_cond = s.test;
      default: grp_cond = 1'b0;
    endcase
  endfunction

  // Square wave for a rate code: a higher rate uses a lower counter bit.
  function automatic logic rate_wave(input logic [1:0] sel, input logic [TCNT_W-1:0] tc);
    case (sel)
      2'd0:    rate_wave = tc[4];
      2'd1:    rate_wave = tc[3];
      2'd2:    rate_wave = tc[2];
      default: rate_wave = tc[1];
    endcase
  endfunction

  // Low tick-count bits that wrap once per full period of a rate code.
  function automatic logic [TCNT_W-1:0] period_mask(input logic [1:0] sel);
    period_mask = 5'h1F >> sel;
  endfunction

endpackage

// File: rtl/phy_led_prescaler.sv
module phy_led_prescaler
  import phy_led_pkg::*;
#(
  parameter int TICK_DIV = 1_953_125
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              tick,
  output logic [TCNT_W-1:0] tcnt
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DW-1:0] div_cnt;

  assign tick = (div_cnt == DW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      tcnt    <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      tcnt    <= tcnt + 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/phy_led_pulse_stretch.sv
module phy_led_pulse_stretch #(
  parameter int PULSE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  output logic busy,
  output logic lit
);
  localparam int CW = $clog2(PULSE_CYC + 1);

  typedef enum logic [1:0] {PS_IDLE, PS_ON, PS_GAP} ps_e;

  ps_e           st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= PS_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        PS_IDLE: if (evt) begin
          st  <= PS_ON;
          cnt <= CW'(PULSE_CYC - 1);
        end
        PS_ON: if (cnt == '0) begin
          st  <= PS_GAP;
          cnt <= CW'(PULSE_CYC - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        PS_GAP: if (cnt == '0) st <= PS_IDLE;
                else           cnt <= cnt - 1'b1;
        default: st <= PS_IDLE;
      endcase
    end
  end

  assign lit  = (st == PS_ON);
  assign busy = (st != PS_IDLE);
endmodule

// File: rtl/phy_led_channel.sv
module phy_led_channel
  import phy_led_pkg::*;
#(
  parameter int PULSE_CYC = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic [7:0] cfg_hi,
  input  logic [7:0] cfg_lo,
  input  phy_stat_t stat,
  input  logic [2:0] act,        // {collision, rx, tx}
  input  logic      fast_wave,
  input  logic      slow_wave,
  output logic      val,
  output logic      pulse_lit
);
  logic evt, busy;
  logic on_c, fast_c, slow_c;

  // Mask bit 3 is reserved and is paired with a constant zero event.
  assign evt = |(cfg_lo[3:0] & {1'b0, act});

  phy_led_pulse_stretch #(.PULSE_CYC(PULSE_CYC)) u_stretch (
    .clk  (clk),
    .rst_n(rst_n),
    .evt  (evt),
    .busy (busy),
    .lit  (pulse_lit)
  );

  assign on_c   = led_cond(cfg_hi[7:4], stat);
  assign fast_c = led_cond(cfg_hi[3:0], stat);
  assign slow_c = led_cond(cfg_lo[7:4], stat);

  always_comb begin
    if (busy)        val = pulse_lit;
    else if (fast_c) val = fast_wave;
    else if (slow_c) val = slow_wave;
    else             val = on_c;
  end
endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl
  import phy_led_pkg::*;
#(
  parameter int CLK_HZ  = 125_000_000,
  parameter int NUM_LED = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 link_up,
  input  logic [1:0]           link_speed,
  input  logic                 power_down,
  input  logic                 eee_active,
  input  logic                 aneg_busy,
  input  logic                 selftest_busy,
  input  logic                 cablediag_busy,
  input  logic                 testmode_on,
  input  logic                 act_tx,
  input  logic                 act_rx,
  input  logic                 act_col,
  input  logic [1:0]           fast_rate,
  input  logic [1:0]           slow_rate,
  input  logic [2:0]           scan_cond,
  input  logic [2:0]           gblink_cond,
  input  logic [NUM_LED*8-1:0] led_hi_cfg,
  input  logic [NUM_LED*8-1:0] led_lo_cfg,
  output logic [NUM_LED-1:0]   led_out
);
  localparam int TICK_DIV  = (CLK_HZ / TICKS_PER_S > 0) ? CLK_HZ / TICKS_PER_S : 1;
  localparam int PULSE_CYC = 2 * TICK_DIV;
  localparam int PW        = (NUM_LED > 1) ? $clog2(NUM_LED) : 1;

  phy_stat_t         stat;
  logic              tick;
  logic [TCNT_W-1:0] tcnt;
  logic              fast_wave, slow_wave;
  logic              scan_act, cblink_act, scan_step;
  logic [PW-1:0]     scan_pos;
  logic [NUM_LED-1:0] chan_val, pulse_lit, led_next;

  assign stat = '{link: link_up, speed: link_speed, pdown: power_down,
                  eee: eee_active, aneg: aneg_busy, abist: selftest_busy,
                  cdiag: cablediag_busy, test: testmode_on};

  phy_led_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .tcnt (tcnt)
  );

  assign fast_wave  = rate_wave(fast_rate, tcnt);
  assign slow_wave  = rate_wave(slow_rate, tcnt);
  assign scan_act   = grp_cond(scan_cond, stat);
  assign cblink_act = grp_cond(gblink_cond, stat);
  assign scan_step  = tick && ((tcnt & period_mask(fast_rate)) == period_mask(fast_rate));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LED; gi++) begin : g_led
      phy_led_channel #(.PULSE_CYC(PULSE_CYC)) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_hi   (led_hi_cfg[gi*8 +: 8]),
        .cfg_lo   (led_lo_cfg[gi*8 +: 8]),
        .stat     (stat),
        .act      ({act_col, act_rx, act_tx}),
        .fast_wave(fast_wave),
        .slow_wave(slow_wave),
        .val      (chan_val[gi]),
        .pulse_lit(pulse_lit[gi])
      );

      always_comb begin
        if (scan_act)        led_next[gi] = (scan_pos == PW'(gi));
        else if (cblink_act) led_next[gi] = slow_wave;
        else                 led_next[gi] = chan_val[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_pos <= '0;
    end else if (!scan_act) begin
      scan_pos <= '0;
    end else if (scan_step) begin
      scan_pos <= (scan_pos == PW'(NUM_LED - 1)) ? '0 : scan_pos + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_out <= '0;
    else        led_out <= led_next;
  end
endmodule

// File: rtl/phy_led_ctrl_chk.sv
module phy_led_ctrl_chk
  import phy_led_pkg::*;
#(
  parameter int NUM_LED = 4,
  parameter int PW      = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_LED-1:0] led_out,
  input logic               tick,
  input logic [TCNT_W-1:0]  tcnt,
  input logic               scan_act,
  input logic               cblink_act,
  input logic [PW-1:0]      scan_pos,
  input logic [NUM_LED-1:0] pulse_lit
);
  always @(negedge clk) begin
    if (!rst_n) assert_reset_R1: assert (led_out == '0);
  end

  assert_wave_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tcnt));

  assert_scan_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_act |=> ($countones(led_out) == 1));

  assert_scan_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(scan_pos) && $past(scan_act)) |->
      (scan_pos == (($past(scan_pos) == PW'(NUM_LED - 1)) ? '0 : $past(scan_pos) + 1'b1)));

  assert_gblink_uniform_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cblink_act && !scan_act) |=> (led_out == '0 || led_out == '1));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LED; gi++) begin : g_pa
      assert_pulse_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_lit[gi]) |=> !pulse_lit[gi]);
    end
  endgenerate
endmodule

bind phy_led_ctrl phy_led_ctrl_chk #(.NUM_LED(NUM_LED), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .led_out   (led_out),
  .tick      (tick),
  .tcnt      (tcnt),
  .scan_act  (scan_act),
  .cblink_act(cblink_act),
  .scan_pos  (scan_pos),
  .pulse_lit (pulse_lit)
);

// File: tb/phy_led_ctrl_bench.sv
module phy_led_ctrl_bench;
  localparam int CLK_HZ = 640;       // 10 cycles per tick
  localparam int N      = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_up = 0, power_down = 0, eee_active = 0, aneg_busy = 0;
  logic selftest_busy = 0, cablediag_busy = 0, testmode_on = 0;
  logic [1:0] link_speed = 2'd3;
  logic act_tx = 0, act_rx = 0, act_col = 0;
  logic [1:0] fast_rate = 0, slow_rate = 0;
  logic [2:0] scan_cond = 0, gblink_cond = 0;
  logic [N*8-1:0] led_hi_cfg = '0, led_lo_cfg = '0;
  logic [N-1:0] led_out;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  phy_led_ctrl #(.CLK_HZ(CLK_HZ), .NUM_LED(N)) u_phy_led_ctrl (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .link_speed(link_speed),
    .power_down(power_down), .eee_active(eee_active), .aneg_busy(aneg_busy),
    .selftest_busy(selftest_busy), .cablediag_busy(cablediag_busy),
    .testmode_on(testmode_on), .act_tx(act_tx), .act_rx(act_rx), .act_col(act_col),
    .fast_rate(fast_rate), .slow_rate(slow_rate), .scan_cond(scan_cond),
    .gblink_cond(gblink_cond), .led_hi_cfg(led_hi_cfg), .led_lo_cfg(led_lo_cfg),
    .led_out(led_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    {link_up, power_down, eee_active, aneg_busy, selftest_busy, cablediag_busy, testmode_on} = '0;
    link_speed = 2'd3;
    {act_tx, act_rx, act_col} = '0;
    scan_cond = 0; gblink_cond = 0;
    led_hi_cfg = '0; led_lo_cfg = '0;
    repeat (45) @(negedge clk);   // let any pulse and gap finish
  endtask

  // Period and high time of one LED, sampled on falling edges.
  task automatic measure(input int idx, output int per, output int hi);
    int c = 0;
    per = 0; hi = 0;
    while (led_out[idx] !== 1'b0 && c < 2000) begin @(negedge clk); c++; end
    while (led_out[idx] !== 1'b1 && c < 2000) begin @(negedge clk); c++; end
    while (led_out[idx] === 1'b1 && hi < 2000) begin hi++; @(negedge clk); end
    per = hi;
    while (led_out[idx] === 1'b0 && per < 4000) begin per++; @(negedge clk); end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(led_out == '0, "R1 reset", int'(led_out), 0);
    led_hi_cfg = 32'h7777_7777;
    link_up = 1; link_speed = 2'd2;
    @(negedge clk);
    chk(led_out == '0, "R1 reset holds", int'(led_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    clear_all();
  endtask

  // One R3 case on LED1; also checks the one-edge latency of R10.
  task automatic const_case(input logic [3:0] code, input logic lk, input logic [1:0] spd,
                            input logic [5:0] st, input logic exp);
    led_hi_cfg[15:8] = {code, 4'h0};
    link_up = lk; link_speed = spd;
    {power_down, eee_active, aneg_busy, selftest_busy, cablediag_busy, testmode_on} = st;
    @(negedge clk);
    chk(led_out[1] == exp, $sformatf("R3/R10 code %h", code), int'(led_out[1]), int'(exp));
  endtask

  task automatic t_const();
    const_case(4'h7, 1, 2'd2, 6'h00, 1);
    const_case(4'h7, 0, 2'd2, 6'h00, 0);
    const_case(4'h7, 1, 2'd3, 6'h00, 0);
    const_case(4'h1, 1, 2'd0, 6'h00, 1);
    const_case(4'h1, 1, 2'd1, 6'h00, 0);
    const_case(4'h3, 1, 2'd1, 6'h00, 1);
    const_case(4'h5, 1, 2'd1, 6'h00, 0);
    const_case(4'h6, 1, 2'd1, 6'h00, 1);
    const_case(4'h4, 1, 2'd2, 6'h00, 1);
    const_case(4'h8, 0, 2'd3, 6'h20, 1);
    const_case(4'h9, 0, 2'd3, 6'h10, 1);
    const_case(4'hA, 0, 2'd3, 6'h08, 1);
    const_case(4'hB, 0, 2'd3, 6'h04, 1);
    const_case(4'hC, 0, 2'd3, 6'h02, 1);
    const_case(4'hD, 1, 2'd2, 6'h3F, 0);
    const_case(4'hF, 1, 2'd2, 6'h3F, 0);
    const_case(4'h0, 1, 2'd2, 6'h3F, 0);
    clear_all();
  endtask

  task automatic t_blink_codes();
    bit lit = 0;
    link_up = 1; link_speed = 2'd2; fast_rate = 3; slow_rate = 3;
    {power_down, eee_active, aneg_busy, selftest_busy, cablediag_busy, testmode_on} = '1;
    led_hi_cfg[7:0] = 8'h0D; led_lo_cfg[7:0] = 8'hE0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (led_out[0]) lit = 1;
    end
    chk(!lit, "R4 codes D-F stay dark", int'(lit), 0);
    clear_all();
  endtask

  task automatic t_rates();
    int per, hi;
    link_up = 1; link_speed = 2'd2;
    led_hi_cfg[23:16] = 8'h04;
    fast_rate = 3;
    measure(2, per, hi);
    chk(per == 40 && hi == 20, "R2 fast 16Hz", per, 40);
    fast_rate = 0;
    measure(2, per, hi);
    chk(per == 320 && hi == 160, "R2 fast 2Hz", per, 320);
    led_hi_cfg[23:16] = 8'h00; led_lo_cfg[23:16] = 8'h40;
    slow_rate = 2;
    measure(2, per, hi);
    chk(per == 80 && hi == 40, "R2/R4 slow 8Hz", per, 80);
    slow_rate = 1;
    measure(2, per, hi);
    chk(per == 160 && hi == 80, "R2/R4 slow 4Hz", per, 160);
    clear_all();
  endtask

  task automatic t_pulse();
    int hi = 0;
    bit stray = 0, relit = 0;
    led_lo_cfg = {8'h04, 8'h08, 8'h02, 8'h01};   // LED3 col, LED2 reserved, LED1 rx, LED0 tx
    act_tx = 1; @(negedge clk); act_tx = 0;
    // Sample 1 was taken above; the LED is lit on samples 2..21.
    for (int j = 2; j <= 40; j++) begin
      @(negedge clk);
      if (led_out[0]) hi++;
      if (led_out[1] || led_out[2] || led_out[3]) stray = 1;
      if (j == 25) act_tx = 1;
      if (j == 26) act_tx = 0;
    end
    chk(hi == 20, "R5 pulse length", hi, 20);
    chk(!stray, "R5 mask selects tx only", int'(stray), 0);
    for (int j = 0; j < 25; j++) begin
      @(negedge clk);
      if (led_out[0]) relit = 1;
    end
    chk(!relit, "R5 retrigger in gap ignored", int'(relit), 0);
    act_tx = 1; act_rx = 1; act_col = 1; @(negedge clk);
    act_tx = 0; act_rx = 0; act_col = 0;
    repeat (3) @(negedge clk);
    chk(led_out == 4'b1011, "R5 reserved bit never pulses", int'(led_out), 11);
    clear_all();
  endtask

  task automatic t_priority();
    int per, hi;
    link_up = 1; link_speed = 2'd2; fast_rate = 3; slow_rate = 2;
    led_hi_cfg[7:0] = 8'h74; led_lo_cfg[7:0] = 8'h40;
    measure(0, per, hi);
    chk(per == 40, "R6 fast over slow and const", per, 40);
    led_hi_cfg[7:0] = 8'h70;
    measure(0, per, hi);
    chk(per == 80, "R6 slow over const", per, 80);
    led_lo_cfg[7:0] = 8'h01;
    repeat (3) @(negedge clk);
    chk(led_out[0] == 1, "R6 const on", int'(led_out[0]), 1);
    act_tx = 1; @(negedge clk); act_tx = 0;
    repeat (29) @(negedge clk);
    chk(led_out[0] == 0, "R6 pulse gap over const", int'(led_out[0]), 0);
    repeat (20) @(negedge clk);
    chk(led_out[0] == 1, "R6 const after pulse", int'(led_out[0]), 1);
    clear_all();
  endtask

  task automatic t_phase();
    bit same = 1, saw0 = 0, saw1 = 0;
    link_up = 1; link_speed = 2'd2; fast_rate = 3;
    led_hi_cfg[7:0] = 8'h04; led_hi_cfg[15:8] = 8'h07;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (led_out[0] != led_out[1]) same = 0;
      if (led_out[0]) saw1 = 1; else saw0 = 1;
    end
    chk(same && saw0 && saw1, "R9 same rate in phase", int'(same), 1);
    clear_all();
  endtask

  task automatic t_scan();
    bit onehot = 1, order = 1, gap = 1;
    int last_chg = -1;
    logic [N-1:0] prev;
    link_up = 1; fast_rate = 3; scan_cond = 3'd1;
    @(negedge clk);
    chk(led_out == 4'b0001, "R8 scan starts at LED0", int'(led_out), 1);
    prev = led_out;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if ($countones(led_out) != 1) onehot = 0;
      if (led_out != prev) begin
        if (led_out != {prev[N-2:0], prev[N-1]}) order = 0;
        if (last_chg >= 0 && i - last_chg != 40) gap = 0;
        last_chg = i;
      end
      prev = led_out;
    end
    chk(onehot, "R8 single lit LED", int'(onehot), 1);
    chk(order, "R8 step order", int'(order), 1);
    chk(gap && last_chg >= 0, "R8 step interval 40", int'(gap), 1);
    gblink_cond = 3'd1;
    onehot = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if ($countones(led_out) != 1) onehot = 0;
    end
    chk(onehot, "R8 scan over group blink", int'(onehot), 1);
    scan_cond = 3'd7;
    clear_all();
  endtask

  task automatic t_gblink();
    int per, hi;
    bit uni = 1;
    link_up = 1; link_speed = 2'd2; slow_rate = 1; gblink_cond = 3'd1;
    led_hi_cfg[7:0] = 8'h70;
    @(negedge clk);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!(led_out == '0 || led_out == '1)) uni = 0;
    end
    chk(uni, "R7 all LEDs together", int'(uni), 1);
    measure(3, per, hi);
    chk(per == 160 && hi == 80, "R7 slow rate", per, 160);
    gblink_cond = 3'd7;
    repeat (2) @(negedge clk);
    chk(led_out == 4'b0001, "R7 condition false", int'(led_out), 1);
    clear_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_const();
    t_blink_codes();
    t_rates();
    t_pulse();
    t_priority();
    t_phase();
    t_scan();
    t_gblink();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule